// File: doc/BRIEF.md
# Software Interrupt Entry Sequencer

This block carries out the hardware side of a software-raised interrupt on a CPU with 16-bit data words. A one-cycle trigger carries a vector number. The sequencer then walks a fixed series of steps:

1. It flushes the pipeline, clears the pending flag for the vector and, if a repeat prefix was active, resets the repeat counter.
2. It reads the 32-bit vector from memory.
3. It pushes the CPU context onto the stack as seven 32-bit pair writes.
4. It clears the vector's enable bit.
5. It loads the program counter, the stack pointer and the mode flags in one final cycle.

A control unit uses it by pulsing the trigger and waiting for the done pulse. The register values, the stack pointer and the program counter are sampled in the trigger cycle. Memory is reached through a 32-bit write port with a ready handshake and a separate vector read port with a valid handshake.

Top module: `swi_entry_seq`

## Requirements
- R1: Each context pair is written as one 32-bit word. The low register is in bits 15:0 and the high register is in bits 31:16. Write k (k = 0..6) goes to word address SP0 + 1 + 2k, with SP0 the stack pointer at the trigger, wrapped to the stack pointer width and with bit 0 forced to 0.
- R2: The seven writes go out in this order, shown as high:low: temp-reg:status0, acc-high:acc-low, prod-high:prod-low, aux1:aux0, data-page:status1, debug-status:irq-enable, and last the return address. Register values are those present in the trigger cycle.
- R3: In the final cycle the stack pointer output equals SP0 + 13 and is written exactly once per run.
- R4: The seventh write carries PC + 1, where PC is the program counter at the trigger. The value is truncated to PC_W bits and zero-extended to 32 bits.
- R5: In the flush cycle the pending-flag clear mask equals 1 << vector. When the vector equals NMI_IDX, the mask stays all zero for the whole run.
- R6: One flush pulse and the vector read happen before the first stack write. The read address is VEC_BASE + 2 × vector. The program counter is loaded with bits PC_W-1:0 of the fetched word.
- R7: The enable-clear mask 1 << vector pulses for one cycle, after the sixth write has been accepted and before the seventh is accepted.
- R8: The mode flags are written together with the program counter. Bit 0 (maskable interrupt mask) and bit 1 (debug event mask) are set to 1. Bit 2 (protected write enable), bit 3 (loop flag) and bit 4 (idle flag) are cleared to 0. Bits above 4 pass through from the flags input.
- R9: If the repeat-pending input is high at the trigger, the repeat-counter clear output pulses once in the flush cycle and the sequence runs exactly once.
- R10: Busy rises in the cycle after the trigger and stays high until the program-counter load cycle, inclusive. Done pulses for one cycle right after that, with busy low.
- R11: A trigger that arrives while a run is in progress is ignored: the run in progress completes unchanged and no second run starts.
- R12: A stack write holds its address and data until write-ready is seen high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Start request |
| trig_vec_i | input | VEC_W | Vector number of the request |
| rpt_pending_i | input | 1 | A repeat prefix precedes this request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_i | input | PC_W | Current program counter |
| treg_i | input | WORD_W | Temporary register |
| stat0_i | input | WORD_W | Status register 0 |
| acc_hi_i | input | WORD_W | Accumulator high half |
| acc_lo_i | input | WORD_W | Accumulator low half |
| prod_hi_i | input | WORD_W | Product register high half |
| prod_lo_i | input | WORD_W | Product register low half |
| aux1_i | input | WORD_W | Auxiliary register 1 |
| aux0_i | input | WORD_W | Auxiliary register 0 |
| dpage_i | input | WORD_W | Data page register |
| stat1_i | input | WORD_W | Status register 1 |
| dbg_stat_i | input | WORD_W | Debug status register |
| irq_en_i | input | WORD_W | Interrupt enable register value to save |
| sp_i | input | SP_W | Stack pointer |
| sp_o | output | SP_W | New stack pointer |
| sp_we_o | output | 1 | Stack pointer write strobe |
| mem_wr_o | output | 1 | Stack write request |
| mem_waddr_o | output | SP_W | Even word address of the write |
| mem_wdata_o | output | 2*WORD_W | Pair data |
| mem_wrdy_i | input | 1 | Write accepted |
| vec_rd_o | output | 1 | Vector read request |
| vec_raddr_o | output | VADDR_W | Vector address |
| vec_rdata_i | input | 2*WORD_W | Fetched vector |
| vec_rvalid_i | input | 1 | Fetched vector valid |
| irq_flag_clr_o | output | NUM_VEC | Pending-flag clear mask |
| irq_en_clr_o | output | NUM_VEC | Enable clear mask |
| flush_o | output | 1 | Pipeline flush pulse |
| rptc_clr_o | output | 1 | Repeat counter clear pulse |
| flags_i | input | FLAG_W | Current mode flags |
| flags_o | output | FLAG_W | Updated mode flags |
| flags_we_o | output | 1 | Mode flag write strobe |
| pc_o | output | PC_W | New program counter |
| pc_we_o | output | 1 | Program counter write strobe |

## Verification
The bench builds the block with NMI_IDX set to 5, VEC_BASE at 0x000D00, 32 vectors and SNAPSHOT enabled. With the special vector that low, the table can reach it next to vectors 0 and 31. The base offset makes the 2 × vector term show up in the read address. With snapshot capture enabled, a directed run can change the register inputs, stack pointer and program counter after the trigger and then show that the pushed words still hold the trigger-cycle values. Write-ready latencies from zero to five cycles, odd and even starting stack pointers, and a stack pointer close to the top of its range exercise the handshake hold, the even alignment and the address wrap.

// File: rtl/swi_entry_pkg.sv
package swi_entry_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FLUSH,
      ST_FETCH,
      ST_PUSH,
      ST_FINISH,
      ST_DONE
   } seq_state_e;

   // seven stack writes: six register pairs and the return address
   localparam int unsigned PAIR_CNT = 7;
   localparam int unsigned REG_CNT  = 2 * (PAIR_CNT - 1);
   localparam int unsigned RET_STEP = PAIR_CNT - 1;
   localparam int unsigned IEN_STEP = PAIR_CNT - 2;

   // mode flag bit positions
   localparam int unsigned FLG_IRQ_MASK = 0;
   localparam int unsigned FLG_DBG_MASK = 1;
   localparam int unsigned FLG_PROT_WR  = 2;
   localparam int unsigned FLG_LOOP     = 3;
   localparam int unsigned FLG_IDLE     = 4;
   localparam int unsigned FLG_MIN_W    = 5;

   function automatic bit flag_forced(input int unsigned idx);
      return idx < FLG_MIN_W;
   endfunction

   function automatic bit flag_set_value(input int unsigned idx);
      return (idx == FLG_IRQ_MASK) || (idx == FLG_DBG_MASK);
   endfunction

endpackage

// File: rtl/swi_vec_map.sv
module swi_vec_map #(
   parameter int unsigned NUM_VEC  = 32,
   parameter int unsigned NMI_IDX  = 18,
   parameter int unsigned VADDR_W  = 22,
   parameter logic [VADDR_W-1:0] VEC_BASE = '0,
   localparam int unsigned VEC_W   = $clog2(NUM_VEC)
) (
   input  logic [VEC_W-1:0]   vec_i,
   output logic [VADDR_W-1:0] vec_addr_o,
   output logic [NUM_VEC-1:0] sel_o,
   output logic               is_nmi_o
);

   initial begin : p_param_chk
      assert (NMI_IDX < NUM_VEC) else $error("swi_vec_map: NMI_IDX out of range");
      assert (VADDR_W > VEC_W)   else $error("swi_vec_map: VADDR_W too narrow");
   end

   for (genvar g = 0; g < NUM_VEC; g++) begin : g_sel
      assign sel_o[g] = (vec_i == VEC_W'(g));
   end

   assign is_nmi_o   = (vec_i == VEC_W'(NMI_IDX));
   // each vector entry occupies two 16-bit words
   assign vec_addr_o = VEC_BASE + (VADDR_W'(vec_i) << 1);

endmodule

// File: rtl/swi_ctx_store.sv
module swi_ctx_store
   import swi_entry_pkg::*;
#(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned PC_W     = 22,
   parameter bit          SNAPSHOT = 1'b1,
   localparam int unsigned PAIR_W  = 2 * WORD_W,
   localparam int unsigned CTX_W   = REG_CNT * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic [CTX_W-1:0]  ctx_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [2:0]        step_i,
   output logic [PAIR_W-1:0] pair_o
);

   initial begin : p_param_chk
      assert (PC_W <= PAIR_W) else $error("swi_ctx_store: PC_W wider than a pair");
   end

   logic [CTX_W-1:0]  ctx_q;
   logic [PC_W-1:0]   ret_q;
   logic [PAIR_W-1:0] pair_w [PAIR_CNT];

   if (SNAPSHOT) begin : g_snap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         ctx_q <= '0;
         else if (capture_i) ctx_q <= ctx_i;
      end
   end else begin : g_live
      assign ctx_q = ctx_i;
   end

   // return address is always taken at the trigger
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ret_q <= '0;
      else if (capture_i) ret_q <= pc_i + PC_W'(1);
   end

   for (genvar g = 0; g < PAIR_CNT - 1; g++) begin : g_pair
      assign pair_w[g] = {ctx_q[(2*g+1)*WORD_W +: WORD_W], ctx_q[2*g*WORD_W +: WORD_W]};
   end
   assign pair_w[RET_STEP] = PAIR_W'(ret_q);

   always_comb begin
      pair_o = '0;
      if (32'(step_i) < PAIR_CNT) pair_o = pair_w[step_i];
   end

endmodule

// File: rtl/swi_flag_update.sv
module swi_flag_update
   import swi_entry_pkg::*;
#(
   parameter int unsigned FLAG_W = 8
) (
   input  logic [FLAG_W-1:0] flags_i,
   output logic [FLAG_W-1:0] flags_o
);

   initial begin : p_param_chk
      assert (FLAG_W >= FLG_MIN_W) else $error("swi_flag_update: FLAG_W too small");
   end

   for (genvar g = 0; g < FLAG_W; g++) begin : g_bit
      if (flag_forced(g)) begin : g_forced
         assign flags_o[g] = flag_set_value(g);
      end else begin : g_pass
         assign flags_o[g] = flags_i[g];
      end
   end

endmodule

// File: rtl/swi_entry_seq.sv
module swi_entry_seq
   import swi_entry_pkg::*;
#(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned PC_W     = 22,
   parameter int unsigned SP_W     = 16,
   parameter int unsigned VADDR_W  = 22,
   parameter int unsigned NUM_VEC  = 32,
   parameter int unsigned NMI_IDX  = 18,
   parameter logic [VADDR_W-1:0] VEC_BASE = 22'h000D00,
   parameter int unsigned FLAG_W   = 8,
   parameter bit          SNAPSHOT = 1'b1,
   localparam int unsigned VEC_W   = $clog2(NUM_VEC),
   localparam int unsigned PAIR_W  = 2 * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trig_i,
   input  logic [VEC_W-1:0]   trig_vec_i,
   input  logic               rpt_pending_i,
   output logic               busy_o,
   output logic               done_o,
   input  logic [PC_W-1:0]    pc_i,
   input  logic [WORD_W-1:0]  treg_i,
   input  logic [WORD_W-1:0]  stat0_i,
   input  logic [WORD_W-1:0]  acc_hi_i,
   input  logic [WORD_W-1:0]  acc_lo_i,
   input  logic [WORD_W-1:0]  prod_hi_i,
   input  logic [WORD_W-1:0]  prod_lo_i,
   input  logic [WORD_W-1:0]  aux1_i,
   input  logic [WORD_W-1:0]  aux0_i,
   input  logic [WORD_W-1:0]  dpage_i,
   input  logic [WORD_W-1:0]  stat1_i,
   input  logic [WORD_W-1:0]  dbg_stat_i,
   input  logic [WORD_W-1:0]  irq_en_i,
   input  logic [SP_W-1:0]    sp_i,
   output logic [SP_W-1:0]    sp_o,
   output logic               sp_we_o,
   output logic               mem_wr_o,
   output logic [SP_W-1:0]    mem_waddr_o,
   output logic [PAIR_W-1:0]  mem_wdata_o,
   input  logic               mem_wrdy_i,
   output logic               vec_rd_o,
   output logic [VADDR_W-1:0] vec_raddr_o,
   input  logic [PAIR_W-1:0]  vec_rdata_i,
   input  logic               vec_rvalid_i,
   output logic [NUM_VEC-1:0] irq_flag_clr_o,
   output logic [NUM_VEC-1:0] irq_en_clr_o,
   output logic               flush_o,
   output logic               rptc_clr_o,
   input  logic [FLAG_W-1:0]  flags_i,
   output logic [FLAG_W-1:0]  flags_o,
   output logic               flags_we_o,
   output logic [PC_W-1:0]    pc_o,
   output logic               pc_we_o
);

   localparam int unsigned CTX_W  = REG_CNT * WORD_W;
   localparam int unsigned SP_ADV = 2 * PAIR_CNT - 1;

   initial begin : p_param_chk
      assert (WORD_W == 16)       else $error("swi_entry_seq: WORD_W must be 16");
      assert (NUM_VEC >= 2)       else $error("swi_entry_seq: NUM_VEC too small");
      assert (SP_W >= 4)          else $error("swi_entry_seq: SP_W too small");
      assert (PC_W <= PAIR_W)     else $error("swi_entry_seq: PC_W too wide");
   end

   seq_state_e          state_q;
   logic [2:0]          step_q;
   logic [VEC_W-1:0]    vec_q;
   logic                rpt_q;
   logic                ier_clr_q;
   logic [SP_W-1:0]     sp_base_q;
   logic [PC_W-1:0]     target_q;

   logic                accept;
   logic                wr_accept;
   logic                last_step;
   logic [SP_W-1:0]     push_addr;
   logic [CTX_W-1:0]    ctx_flat;
   logic [PAIR_W-1:0]   pair_data;
   logic [VADDR_W-1:0]  vec_addr;
   logic [NUM_VEC-1:0]  vec_sel;
   logic                vec_is_nmi;
   logic [FLAG_W-1:0]   flags_next;

   assign accept    = (state_q == ST_IDLE) && trig_i;
   assign wr_accept = (state_q == ST_PUSH) && mem_wrdy_i;
   assign last_step = (step_q == 3'(RET_STEP));

   // low register of pair k at slot 2k, high register at slot 2k+1
   assign ctx_flat = {dbg_stat_i, irq_en_i, dpage_i, stat1_i, aux1_i, aux0_i,
                      prod_hi_i, prod_lo_i, acc_hi_i, acc_lo_i, treg_i, stat0_i};

   swi_vec_map #(
      .NUM_VEC  (NUM_VEC),
      .NMI_IDX  (NMI_IDX),
      .VADDR_W  (VADDR_W),
      .VEC_BASE (VEC_BASE)
   ) i_vec_map (
      .vec_i      (vec_q),
      .vec_addr_o (vec_addr),
      .sel_o      (vec_sel),
      .is_nmi_o   (vec_is_nmi)
   );

   swi_ctx_store #(
      .WORD_W   (WORD_W),
      .PC_W     (PC_W),
      .SNAPSHOT (SNAPSHOT)
   ) i_ctx_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (accept),
      .ctx_i     (ctx_flat),
      .pc_i      (pc_i),
      .step_i    (step_q),
      .pair_o    (pair_data)
   );

   swi_flag_update #(
      .FLAG_W (FLAG_W)
   ) i_flag_update (
      .flags_i (flags_i),
      .flags_o (flags_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         step_q    <= '0;
         vec_q     <= '0;
         rpt_q     <= 1'b0;
         ier_clr_q <= 1'b0;
         sp_base_q <= '0;
         target_q  <= '0;
      end else begin
         ier_clr_q <= wr_accept && (step_q == 3'(IEN_STEP));
         unique case (state_q)
            ST_IDLE: begin
               if (trig_i) begin
                  vec_q     <= trig_vec_i;
                  rpt_q     <= rpt_pending_i;
                  sp_base_q <= sp_i;
                  step_q    <= '0;
                  state_q   <= ST_FLUSH;
               end
            end
            ST_FLUSH: state_q <= ST_FETCH;
            ST_FETCH: begin
               if (vec_rvalid_i) begin
                  target_q <= vec_rdata_i[PC_W-1:0];
                  state_q  <= ST_PUSH;
               end
            end
            ST_PUSH: begin
               if (mem_wrdy_i) begin
                  if (last_step) state_q <= ST_FINISH;
                  else           step_q  <= step_q + 3'd1;
               end
            end
            ST_FINISH: state_q <= ST_DONE;
            ST_DONE:   state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   assign push_addr = sp_base_q + SP_W'(1) + SP_W'({step_q, 1'b0});

   assign busy_o         = (state_q != ST_IDLE) && (state_q != ST_DONE);
   assign done_o         = (state_q == ST_DONE);
   assign flush_o        = (state_q == ST_FLUSH);
   assign rptc_clr_o     = (state_q == ST_FLUSH) && rpt_q;
   assign irq_flag_clr_o = ((state_q == ST_FLUSH) && !vec_is_nmi) ? vec_sel : '0;
   assign vec_rd_o       = (state_q == ST_FETCH);
   assign vec_raddr_o    = vec_addr;
   assign mem_wr_o       = (state_q == ST_PUSH);
   assign mem_waddr_o    = {push_addr[SP_W-1:1], 1'b0};
   assign mem_wdata_o    = pair_data;
   assign irq_en_clr_o   = ier_clr_q ? vec_sel : '0;
   assign sp_we_o        = (state_q == ST_FINISH);
   assign sp_o           = sp_base_q + SP_W'(SP_ADV);
   assign flags_we_o     = (state_q == ST_FINISH);
   assign flags_o        = flags_next;
   assign pc_we_o        = (state_q == ST_FINISH);
   assign pc_o           = target_q;

   // R1: consecutive accepted pair writes advance by two words
   a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_accept && !last_step) |=> (mem_wr_o && mem_waddr_o == $past(mem_waddr_o) + SP_W'(2)));

   // R12: an unacknowledged write keeps address and data
   a_r12_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_o && !mem_wrdy_i) |=> (mem_wr_o && $stable(mem_waddr_o) && $stable(mem_wdata_o)));

   // R6: the first stack write follows an accepted vector read
   a_r6_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_o) |-> $past(vec_rd_o && vec_rvalid_i));

   // R7: enable clear appears only while the return address is pending
   a_r7_ien_clr_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en_clr_o != '0) |-> (mem_wr_o && last_step && $countones(irq_en_clr_o) == 1));

   // R5: pending-flag clear coincides with the flush pulse
   a_r5_flag_clr_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag_clr_o != '0) |-> (flush_o && $onehot0(irq_flag_clr_o)));

   // R9: repeat counter clear only in the flush cycle
   a_r9_rpt_flush: assert property (@(posedge clk) disable iff (!rst_n)
      rptc_clr_o |-> flush_o);

   // R10: done follows the program counter load, with busy released
   a_r10_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      pc_we_o |=> (done_o && !busy_o));

   // R11: a trigger during a run leaves the latched vector untouched
   a_r11_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && trig_i) |=> $stable(vec_q));

endmodule

// File: tb/test_swi_entry_seq.sv
`timescale 1ns/1ps
module test_swi_entry_seq;

   localparam int unsigned NMI = 5;
   localparam logic [21:0] VBASE = 22'h000D00;

   typedef struct packed {
      logic [4:0]  vec;
      logic        rpt;
      logic [3:0]  lat;
      logic [15:0] sp0;
      logic [21:0] pc0;
      logic [7:0]  flg;
      logic [7:0]  seed;
   } vec_t;

   localparam vec_t TBL [0:5] = '{
      '{5'd3,  1'b0, 4'd0, 16'h0401, 22'h001234, 8'hFC, 8'd1},
      '{5'd5,  1'b0, 4'd2, 16'h07FF, 22'h3FFFFF, 8'h00, 8'd2},
      '{5'd0,  1'b1, 4'd1, 16'h0500, 22'h000100, 8'h1F, 8'd3},
      '{5'd31, 1'b0, 4'd3, 16'hFFF9, 22'h2AAAAA, 8'hA5, 8'd4},
      '{5'd14, 1'b1, 4'd0, 16'h0101, 22'h155555, 8'h5A, 8'd5},
      '{5'd17, 1'b0, 4'd5, 16'h1001, 22'h000000, 8'hE0, 8'd6}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        trig = 1'b0;
   logic [4:0]  trig_vec = '0;
   logic        rpt_in = 1'b0;
   logic [21:0] pc_in = '0;
   logic [15:0] r [0:11];
   logic [15:0] sp_in = '0;
   logic [7:0]  flags_in = '0;
   logic        mem_wrdy = 1'b0;
   logic        vec_rvalid = 1'b0;
   logic [31:0] vec_rdata = '0;
   int          cur_lat = 0;

   logic        busy, done, sp_we, mem_wr, vec_rd, flush, rptc_clr, flags_we, pc_we;
   logic [15:0] sp_out, mem_waddr;
   logic [31:0] mem_wdata, ifr_clr, ien_clr;
   logic [21:0] vec_raddr, pc_out;
   logic [7:0]  flags_out;

   swi_entry_seq #(
      .NMI_IDX (NMI), .VEC_BASE (VBASE), .NUM_VEC (32), .SNAPSHOT (1'b1)
   ) i_swi_entry_seq (
      .clk (clk), .rst_n (rst_n), .trig_i (trig), .trig_vec_i (trig_vec),
      .rpt_pending_i (rpt_in), .busy_o (busy), .done_o (done), .pc_i (pc_in),
      .treg_i (r[1]), .stat0_i (r[0]), .acc_hi_i (r[3]), .acc_lo_i (r[2]),
      .prod_hi_i (r[5]), .prod_lo_i (r[4]), .aux1_i (r[7]), .aux0_i (r[6]),
      .dpage_i (r[9]), .stat1_i (r[8]), .dbg_stat_i (r[11]), .irq_en_i (r[10]),
      .sp_i (sp_in), .sp_o (sp_out), .sp_we_o (sp_we),
      .mem_wr_o (mem_wr), .mem_waddr_o (mem_waddr), .mem_wdata_o (mem_wdata),
      .mem_wrdy_i (mem_wrdy), .vec_rd_o (vec_rd), .vec_raddr_o (vec_raddr),
      .vec_rdata_i (vec_rdata), .vec_rvalid_i (vec_rvalid),
      .irq_flag_clr_o (ifr_clr), .irq_en_clr_o (ien_clr), .flush_o (flush),
      .rptc_clr_o (rptc_clr), .flags_i (flags_in), .flags_o (flags_out),
      .flags_we_o (flags_we), .pc_o (pc_out), .pc_we_o (pc_we)
   );

   // ---------------- monitor and memory responders ----------------
   int n_wr = 0, n_flush = 0, n_ifr = 0, n_ien = 0, n_rpt = 0, n_pc = 0, n_done = 0, n_sp = 0;
   logic [15:0] wr_addr [0:255];
   logic [31:0] wr_data [0:255];
   int          wcnt = 0;
   int          flush_at = 0, ien_at = 0, fetch_at = 0;
   logic [31:0] ifr_mask = '0, ien_mask = '0;
   logic [21:0] fetch_addr = '0, pc_cap = '0;
   logic [15:0] sp_cap = '0;
   logic [7:0]  flags_cap = '0;
   logic        flags_with_pc = 1'b0, busy_at_pc = 1'b0, busy_at_done = 1'b1;

   function automatic logic [31:0] vrom(input logic [21:0] a);
      return {10'h2C0, a ^ 22'h15A5A};
   endfunction

   always @(negedge clk) begin
      if (flush) begin n_flush++; flush_at = n_wr; end
      if (ifr_clr != 0) begin n_ifr++; ifr_mask = ifr_clr; end
      if (rptc_clr) n_rpt++;
      if (ien_clr != 0) begin n_ien++; ien_mask = ien_clr; ien_at = n_wr; end
      if (sp_we) begin n_sp++; sp_cap = sp_out; end
      if (pc_we) begin
         n_pc++; pc_cap = pc_out; busy_at_pc = busy;
         flags_with_pc = flags_we; flags_cap = flags_out;
      end
      if (done) begin n_done++; busy_at_done = busy; end
      // vector read port
      if (vec_rvalid) vec_rvalid = 1'b0;
      else if (vec_rd) begin
         vec_rvalid = 1'b1; vec_rdata = vrom(vec_raddr);
         fetch_addr = vec_raddr; fetch_at = n_wr;
      end
      // write port: record when ready is raised, accepted at next edge
      if (mem_wrdy) begin mem_wrdy = 1'b0; wcnt = 0; end
      else if (mem_wr) begin
         if (wcnt >= cur_lat) begin
            mem_wrdy = 1'b1;
            wr_addr[n_wr % 256] = mem_waddr;
            wr_data[n_wr % 256] = mem_wdata;
            n_wr++;
         end else wcnt++;
      end
   end

   // ---------------- checking ----------------
   int n_chk = 0, n_fail = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] rval(input logic [7:0] seed, input int k);
      return 16'(seed * 16'h1357 + k * 16'h0F0F + 16'h00A1);
   endfunction

   task automatic set_regs(input logic [7:0] seed);
      for (int k = 0; k < 12; k++) r[k] = rval(seed, k);
   endtask

   task automatic run_entry(input vec_t e, input bit disturb);
      int b_wr, b_fl, b_ifr, b_ien, b_rpt, b_pc, b_done, b_sp, guard;
      logic [15:0] ea;
      logic [31:0] ed;
      logic [21:0] ret;
      set_regs(e.seed);
      sp_in = e.sp0; pc_in = e.pc0; flags_in = e.flg; rpt_in = e.rpt; cur_lat = e.lat;
      b_wr = n_wr; b_fl = n_flush; b_ifr = n_ifr; b_ien = n_ien; b_rpt = n_rpt;
      b_pc = n_pc; b_done = n_done; b_sp = n_sp;
      @(negedge clk); #1; trig = 1'b1; trig_vec = e.vec;
      @(negedge clk); #1; trig = 1'b0; rpt_in = 1'b0;
      chk("R10 busy after trigger", 32'(busy), 32'd1);
      if (disturb) begin
         set_regs(8'hEE); pc_in = 22'h0ABCDE; sp_in = 16'h3333;
         repeat (3) @(negedge clk);
         #1; trig = 1'b1; trig_vec = e.vec ^ 5'h1F;
         @(negedge clk); #1; trig = 1'b0;
      end
      guard = 0;
      while (n_done == b_done && guard < 2000) begin @(negedge clk); #1; guard++; end
      repeat (3) @(negedge clk);
      #1;
      chk("R10 run completes", 32'(n_done - b_done), 32'd1);
      chk("R1 seven writes", 32'(n_wr - b_wr), 32'd7);
      for (int k = 0; k < 7; k++) begin
         ea = (e.sp0 + 16'd1 + 16'(2 * k)) & 16'hFFFE;
         if (k < 6) ed = {rval(e.seed, 2 * k + 1), rval(e.seed, 2 * k)};
         else begin ret = e.pc0 + 22'd1; ed = {10'h0, ret}; end
         chk($sformatf("R1 address of write %0d", k), 32'(wr_addr[(b_wr + k) % 256]), 32'(ea));
         if (k < 6) chk($sformatf("R2 pair %0d", k), wr_data[(b_wr + k) % 256], ed);
         else       chk("R4 return address", wr_data[(b_wr + k) % 256], ed);
      end
      chk("R3 final stack pointer", 32'(sp_cap), 32'(16'(e.sp0 + 16'd13)));
      chk("R3 single sp write", 32'(n_sp - b_sp), 32'd1);
      chk("R6 one flush", 32'(n_flush - b_fl), 32'd1);
      chk("R6 flush before writes", 32'(flush_at), 32'(b_wr));
      chk("R6 fetch before writes", 32'(fetch_at), 32'(b_wr));
      chk("R6 vector address", 32'(fetch_addr), 32'(VBASE + 22'(e.vec) * 22'd2));
      chk("R6 pc loaded", 32'(pc_cap), 32'(vrom(VBASE + 22'(e.vec) * 22'd2) & 32'h3FFFFF));
      if (e.vec == 5'(NMI)) chk("R5 nmi keeps flag", 32'(n_ifr - b_ifr), 32'd0);
      else begin
         chk("R5 flag clear count", 32'(n_ifr - b_ifr), 32'd1);
         chk("R5 flag clear mask", ifr_mask, 32'd1 << e.vec);
      end
      chk("R7 enable clear count", 32'(n_ien - b_ien), 32'd1);
      chk("R7 enable clear mask", ien_mask, 32'd1 << e.vec);
      chk("R7 enable clear after sixth write", 32'(ien_at), 32'(b_wr + 6));
      chk("R8 flags written with pc", 32'(flags_with_pc), 32'd1);
      chk("R8 flag value", 32'(flags_cap), 32'((e.flg & 8'hE0) | 8'h03));
      chk("R9 repeat clear", 32'(n_rpt - b_rpt), 32'(e.rpt));
      chk("R10 busy at pc load", 32'(busy_at_pc), 32'd1);
      chk("R10 busy low at done", 32'(busy_at_done), 32'd0);
      chk("R10 idle afterwards", 32'(busy), 32'd0);
      if (disturb) chk("R11 single run despite trigger", 32'(n_pc - b_pc), 32'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail + 1);
      $finish;
   end

   initial begin
      set_regs(8'd0);
      repeat (4) @(posedge clk);
      @(negedge clk); #1;
      chk("R10 reset busy", 32'(busy), 32'd0);
      chk("R10 reset done", 32'(done), 32'd0);
      chk("R12 reset no write", 32'(mem_wr), 32'd0);
      chk("R6 reset no fetch", 32'(vec_rd), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // table walk
      for (int i = 0; i <= 5; i++) run_entry(TBL[i], 1'b0);
      // R11 and R2 snapshot: inputs change and a second trigger arrives mid-run
      run_entry('{5'd9, 1'b0, 4'd4, 16'h2001, 22'h000777, 8'h40, 8'd7}, 1'b1);
      // NMI with repeat prefix: still runs once, flag untouched
      run_entry('{5'(NMI), 1'b1, 4'd1, 16'h0041, 22'h000010, 8'hFF, 8'd8}, 1'b0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule